// File: doc/BRIEF.md
# Latency-Slotted Burst Responder

This block plays the memory side of a simplified DDR3 data path. A ring of time slots is walked by a pointer that steps once per clock. Each read or write command reserves a run of consecutive slots a fixed column latency ahead of the pointer. It writes into each slot the direction, the word address of that beat and, for reads, the word fetched from an internal memory at the moment the command arrives. When the pointer lands on a reserved slot, the beat is carried out and the slot is freed.

The controller side drives an encoded command with bank, row and column, and on each data beat it drives the write word, a byte-free data mask bit and the bus output enable. Returned words leave on `rdata` with `rvalid` as their valid strobe. The responder cannot be stalled, so there is no ready: a beat is presented exactly once, and the receiver must take it in that cycle. Strobe timing and double-rate edges are not modelled; each beat is one clock.

Top module: `burst_slot_sched`

## Requirements
- R1: During reset and after it is released, `rdata` is 0 and `rvalid`, `proto_err` and `range_err` are low until a beat is serviced.
- R2: Command code 2'b01 is a write. Beat i (i = 0..3) samples `wdata` and `dm` at the clock edge CL-1+i edges after the edge that took the command (CL = 5), and stores the word at burst base + i.
- R3: Command code 2'b10 is a read. `rvalid` is high, and `rdata` holds the word at burst base + i, in the cycle after edge CL-1+i, for i = 0..3 in ascending order.
- R4: The burst base is the command word address with its two low bits cleared. The column's two low bits do not change which words are moved or their order.
- R5: The word address is {row, bank, col} with row most significant (4 + 3 + 4 bits by default). Row 7, bank 7, col 15 is word 1023.
- R6: A write beat whose `dm` is high leaves that memory word unchanged. The other beats of the burst are stored.
- R7: Read data is fetched when the read command is accepted. A write beat that lands on the same word at that edge or later does not alter the words of that read.
- R8: While `bus_oe` is high, `rdata` after an edge equals the `wdata` sampled at that edge.
- R9: A write beat serviced while `bus_oe` is low raises `proto_err` for the one following cycle. The beat is still stored according to `dm`.
- R10: A beat whose address is 1024 or more (memory size) raises `range_err` for the following cycle. It writes nothing, and a read beat returns 0.
- R11: Command codes 2'b00 and 2'b11 reserve no slot: no `rvalid`, no error flag and no memory change follow.
- R12: A serviced slot is freed. A read burst gives exactly four `rvalid` cycles, and none return when the pointer wraps past the slot again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Command code: 01 write, 10 read, 00/11 none |
| bank | input | BANK_W (3) | Bank of the command |
| row | input | ROW_W (4) | Row of the command |
| col | input | COL_W (4) | Column of the command |
| wdata | input | DW (32) | Write word of the current beat |
| dm | input | 1 | Data mask; high suppresses the store of this beat |
| bus_oe | input | 1 | High while the controller drives the data bus |
| rdata | output | DW (32) | Returned or looped-back word |
| rvalid | output | 1 | A read beat was serviced at the last edge |
| proto_err | output | 1 | A write beat was serviced with the bus not driven |
| range_err | output | 1 | A serviced beat addressed beyond the memory |

## Verification
The hardest case to reach is the capture-at-command rule. The read command has to arrive at exactly the edge where an earlier write to the same burst begins landing its beats. Only then is there a gap between the moment the data is fetched and the moment that data reaches the pins. The stimulus issues a write, counts CL-1 edges, and presents the read command together with the first write beat. It then expects the old words four edges later and the new words from a second read. Address concatenation is pinned by the range flag on the two sides of the 1024 boundary, and slot freeing by watching a full pointer wrap after a burst.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;
endpackage

// File: rtl/sched_store.sv
module sched_store #(
  parameter int DW    = 32,
  parameter int WORDS = 1024,
  parameter int BURST = 4,
  parameter int IW    = 10
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [IW-1:0]              waddr,
  input  logic [DW-1:0]              wdata,
  input  logic [BURST-1:0][IW-1:0]   raddr,
  output logic [BURST-1:0][DW-1:0]   rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // one combinational read port per beat of a burst
  for (genvar j = 0; j < BURST; j++) begin : g_rport
    assign rdata[j] = mem[raddr[j]];
  end
endmodule

// File: rtl/sched_ring.sv
module sched_ring #(
  parameter int SLOTS = 16,
  parameter int CL    = 5,
  parameter int BURST = 4,
  parameter int AW    = 11,
  parameter int DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rsv_en,
  input  logic                      rsv_rd,
  input  logic [AW-1:0]             rsv_base,
  input  logic [BURST-1:0][DW-1:0]  rsv_fill,
  output logic                      svc_used,
  output logic                      svc_rd,
  output logic [AW-1:0]             svc_addr,
  output logic [DW-1:0]             svc_data
);
  localparam int PW = $clog2(SLOTS);
  localparam int BW = $clog2(BURST);

  logic [PW-1:0]    ptr_q, svc_idx;
  logic [SLOTS-1:0] used_q, rd_q, hit;
  logic [AW-1:0]    addr_q [SLOTS];
  logic [DW-1:0]    data_q [SLOTS];
  logic [PW-1:0]    off [SLOTS];

  // the slot serviced at an edge is the one the pointer steps onto
  assign svc_idx = ptr_q + 1'b1;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      off[s] = PW'(s) - ptr_q - PW'(CL);
      hit[s] = rsv_en && (off[s] < PW'(BURST));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      used_q <= '0;
      rd_q   <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        addr_q[s] <= '1;
        data_q[s] <= '0;
      end
    end else begin
      ptr_q <= svc_idx;
      for (int s = 0; s < SLOTS; s++) begin
        if (hit[s]) begin
          used_q[s] <= 1'b1;
          rd_q[s]   <= rsv_rd;
          addr_q[s] <= rsv_base | AW'(off[s][BW-1:0]);
          data_q[s] <= rsv_fill[off[s][BW-1:0]];
        end else if (svc_idx == PW'(s)) begin
          used_q[s] <= 1'b0;
          rd_q[s]   <= 1'b0;
          addr_q[s] <= '1;
        end
      end
    end
  end

  assign svc_used = used_q[svc_idx];
  assign svc_rd   = rd_q[svc_idx];
  assign svc_addr = addr_q[svc_idx];
  assign svc_data = data_q[svc_idx];

  // R2: the pointer moves one slot per clock, so beats land at fixed edges
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ptr_q == PW'($past(ptr_q) + 1'b1));

  // R12: a slot that has just been serviced is free afterwards
  p_slot_freed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    svc_used |=> !used_q[$past(svc_idx)]);
endmodule

// File: rtl/burst_slot_sched.sv
module burst_slot_sched #(
  parameter int DW        = 32,
  parameter int ROW_W     = 4,
  parameter int BANK_W    = 3,
  parameter int COL_W     = 4,
  parameter int MEM_WORDS = 1024,
  parameter int SLOTS     = 16,
  parameter int CL        = 5,
  parameter int BURST     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [DW-1:0]     wdata,
  input  logic              dm,
  input  logic              bus_oe,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              proto_err,
  output logic              range_err
);
  import sched_pkg::*;

  localparam int AW = ROW_W + BANK_W + COL_W;
  localparam int IW = $clog2(MEM_WORDS);
  localparam logic [AW:0] LIMIT = (AW+1)'(MEM_WORDS);

  cmd_e                     cmd_c;
  logic [AW-1:0]            req_addr, base;
  logic [BURST-1:0][AW-1:0] fetch_addr;
  logic [BURST-1:0][IW-1:0] fetch_idx;
  logic [BURST-1:0][DW-1:0] store_q, fill;
  logic                     svc_used, svc_rd, svc_in, store_we;
  logic [AW-1:0]            svc_addr;
  logic [DW-1:0]            svc_data;

  assign cmd_c    = cmd_e'(cmd);
  assign req_addr = {row, bank, col};
  assign base     = req_addr & ~AW'(BURST - 1);

  for (genvar j = 0; j < BURST; j++) begin : g_fetch
    assign fetch_addr[j] = base | AW'(j);
    assign fetch_idx[j]  = fetch_addr[j][IW-1:0];
    assign fill[j]       = ({1'b0, fetch_addr[j]} < LIMIT) ? store_q[j] : '0;
  end

  sched_ring #(.SLOTS(SLOTS), .CL(CL), .BURST(BURST), .AW(AW), .DW(DW)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsv_en   (cmd_c == CMD_WRITE || cmd_c == CMD_READ),
    .rsv_rd   (cmd_c == CMD_READ),
    .rsv_base (base),
    .rsv_fill (fill),
    .svc_used (svc_used),
    .svc_rd   (svc_rd),
    .svc_addr (svc_addr),
    .svc_data (svc_data)
  );

  assign svc_in   = {1'b0, svc_addr} < LIMIT;
  assign store_we = svc_used && !svc_rd && !dm && svc_in;

  sched_store #(.DW(DW), .WORDS(MEM_WORDS), .BURST(BURST), .IW(IW)) u_store (
    .clk   (clk),
    .we    (store_we),
    .waddr (svc_addr[IW-1:0]),
    .wdata (wdata),
    .raddr (fetch_idx),
    .rdata (store_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rvalid    <= 1'b0;
      proto_err <= 1'b0;
      range_err <= 1'b0;
    end else begin
      rdata     <= bus_oe ? wdata : ((svc_used && svc_rd) ? svc_data : '0);
      rvalid    <= svc_used && svc_rd;
      proto_err <= svc_used && !svc_rd && !bus_oe;
      range_err <= svc_used && !svc_in;
    end
  end

  // R11: an edge with no reserved slot produces no beat and no flag
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_used |=> !rvalid && !proto_err && !range_err);

  // R8: a driven bus is looped back on the following cycle
  p_oe_loop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |=> rdata == $past(wdata));

  // R3: a returned beat always stems from a read slot
  p_rvalid_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(svc_rd));

  // R9: a write beat with the bus released is flagged
  p_proto_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_used && !svc_rd && !bus_oe) |=> proto_err);
endmodule

// File: tb/burst_slot_sched_bench.sv
module burst_slot_sched_bench;
  localparam int CLK_NS = 10;
  localparam int CL     = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [2:0]  bank = '0;
  logic [3:0]  row = '0;
  logic [3:0]  col = '0;
  logic [31:0] wdata = '0;
  logic        dm = 1'b0;
  logic        bus_oe = 1'b0;
  logic [31:0] rdata;
  logic        rvalid, proto_err, range_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  burst_slot_sched u_burst_slot_sched (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .row(row), .col(col),
    .wdata(wdata), .dm(dm), .bus_oe(bus_oe), .rdata(rdata), .rvalid(rvalid),
    .proto_err(proto_err), .range_err(range_err)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [3:0] r, input logic [2:0] b, input logic [3:0] c);
    row = r; bank = b; col = c;
  endtask

  task automatic wr_burst(input logic [3:0] r, input logic [2:0] b, input logic [3:0] c,
                          input logic [3:0][31:0] d, input logic [3:0] mask, input logic oe,
                          input logic exp_pe, input logic exp_re, input string req);
    set_addr(r, b, c); cmd = 2'b01;
    tick();
    cmd = 2'b00;
    repeat (CL-2) tick();
    for (int i = 0; i < 4; i++) begin
      wdata = d[i]; dm = mask[i]; bus_oe = oe;
      tick();
      chk({req, " proto_err"}, 32'(proto_err), 32'(exp_pe));
      chk({req, " range_err"}, 32'(range_err), 32'(exp_re));
      if (oe) chk({req, " R8 loopback"}, rdata, d[i]);
    end
    dm = 1'b0; bus_oe = 1'b0;
  endtask

  task automatic rd_burst(input logic [3:0] r, input logic [2:0] b, input logic [3:0] c,
                          input logic [3:0][31:0] e, input logic exp_re, input string req);
    bus_oe = 1'b0;
    set_addr(r, b, c); cmd = 2'b10;
    tick();
    cmd = 2'b00;
    repeat (CL-2) tick();
    for (int i = 0; i < 4; i++) begin
      tick();
      chk({req, " rvalid"}, 32'(rvalid), 32'd1);
      chk({req, " rdata"}, rdata, e[i]);
      chk({req, " range_err"}, 32'(range_err), 32'(exp_re));
    end
    tick();
    chk({req, " rvalid after burst"}, 32'(rvalid), 32'd0);
  endtask

  function automatic logic [3:0][31:0] pat(input logic [31:0] seed);
    logic [3:0][31:0] v;
    for (int i = 0; i < 4; i++) v[i] = seed + 32'(i) * 32'h0101_0101;
    return v;
  endfunction

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 rdata in reset", rdata, 32'd0);
    chk("R1 rvalid in reset", 32'(rvalid), 32'd0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 rdata after reset", rdata, 32'd0);
    chk("R1 rvalid after reset", 32'(rvalid), 32'd0);
    chk("R1 proto_err after reset", 32'(proto_err), 32'd0);
    chk("R1 range_err after reset", 32'(range_err), 32'd0);
  endtask

  task automatic t_basic();
    // R2 R3: row 2 bank 5 col 4 -> word 340
    wr_burst(4'd2, 3'd5, 4'd4, pat(32'hA000_0010), 4'b0000, 1'b1, 1'b0, 1'b0, "R2 write");
    rd_burst(4'd2, 3'd5, 4'd4, pat(32'hA000_0010), 1'b0, "R3 read");
    // R4: column low bits ignored, order still base+0..3
    rd_burst(4'd2, 3'd5, 4'd7, pat(32'hA000_0010), 1'b0, "R4 col 7");
    rd_burst(4'd2, 3'd5, 4'd6, pat(32'hA000_0010), 1'b0, "R4 col 6");
  endtask

  task automatic t_mask();
    logic [3:0][31:0] d, e, x;
    d = pat(32'h1111_0000);
    e = pat(32'h2222_0000);
    wr_burst(4'd0, 3'd0, 4'd0, d, 4'b0000, 1'b1, 1'b0, 1'b0, "R6 prefill");
    wr_burst(4'd0, 3'd0, 4'd0, e, 4'b0010, 1'b1, 1'b0, 1'b0, "R6 masked write");
    x = e; x[1] = d[1];
    rd_burst(4'd0, 3'd0, 4'd0, x, 1'b0, "R6 masked readback");
  endtask

  task automatic t_capture();
    logic [3:0][31:0] g, h;
    g = pat(32'h3333_0000);
    h = pat(32'h4444_0000);
    wr_burst(4'd0, 3'd2, 4'd0, g, 4'b0000, 1'b1, 1'b0, 1'b0, "R7 prefill");
    set_addr(4'd0, 3'd2, 4'd0); cmd = 2'b01;
    tick();
    cmd = 2'b00;
    repeat (CL-2) tick();
    for (int i = 0; i < 4; i++) begin
      cmd = (i == 0) ? 2'b10 : 2'b00;
      wdata = h[i]; bus_oe = 1'b1;
      tick();
    end
    cmd = 2'b00; bus_oe = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R7 rvalid", 32'(rvalid), 32'd1);
      chk("R7 old word kept", rdata, g[i]);
    end
    rd_burst(4'd0, 3'd2, 4'd0, h, 1'b0, "R7 new words later");
  endtask

  task automatic t_proto();
    wr_burst(4'd1, 3'd1, 4'd8, pat(32'h5555_0000), 4'b0000, 1'b0, 1'b1, 1'b0, "R9 undriven write");
    tick();
    chk("R9 flag drops", 32'(proto_err), 32'd0);
    rd_burst(4'd1, 3'd1, 4'd8, pat(32'h5555_0000), 1'b0, "R9 still stored");
  endtask

  task automatic t_range();
    logic [3:0][31:0] z, keep;
    z = '0;
    keep = pat(32'h2222_0000); keep[1] = 32'h1111_0000 + 32'h0101_0101;
    // R5: word 1020..1023 is in range only with row on top
    wr_burst(4'd7, 3'd7, 4'd15, pat(32'h6666_0000), 4'b0000, 1'b1, 1'b0, 1'b0, "R5 top word");
    rd_burst(4'd7, 3'd7, 4'd12, pat(32'h6666_0000), 1'b0, "R5 top readback");
    // R10: row 8 -> 1024 and up
    wr_burst(4'd8, 3'd0, 4'd0, pat(32'h7777_0000), 4'b0000, 1'b1, 1'b0, 1'b1, "R10 write out of range");
    rd_burst(4'd8, 3'd0, 4'd0, z, 1'b1, "R10 read out of range");
    rd_burst(4'd0, 3'd0, 4'd0, keep, 1'b0, "R10 word 0 untouched");
  endtask

  task automatic t_idle();
    int seen;
    seen = 0;
    bus_oe = 1'b0;
    set_addr(4'd0, 3'd0, 4'd0);
    cmd = 2'b11; tick();
    cmd = 2'b00; tick();
    cmd = 2'b11; tick();
    cmd = 2'b00;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (rvalid || proto_err || range_err) seen++;
    end
    chk("R11 idle codes reserve nothing", 32'(seen), 32'd0);
  endtask

  task automatic t_wrap();
    int seen;
    seen = 0;
    rd_burst(4'd2, 3'd5, 4'd4, pat(32'hA000_0010), 1'b0, "R12 read");
    for (int i = 0; i < 20; i++) begin
      tick();
      if (rvalid) seen++;
    end
    chk("R12 no beats after wrap", 32'(seen), 32'd0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_mask();
    t_capture();
    t_proto();
    t_range();
    t_idle();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule